// File: doc/BRIEF.md
# Serial EEPROM Target Command Engine

This block is the device side of a byte-wide serial EEPROM on an SPI bus in mode 0. The bus pins are sampled in the system clock domain. Every transaction opens with an instruction byte. For data access the instruction is followed by an address of one to three bytes, sent most significant byte first. The block then streams bytes out of an internal array, or collects bytes into a one-page buffer. That buffer is written into the array when chip select is released.

A write-enable latch gates every modifying instruction. A busy interval of a fixed number of system clocks follows each internal write, and the latch clears by itself when that interval ends. For small arrays, address bit 8 can travel in bit 3 of the read and write instructions, so a single address byte is enough to reach 512 bytes. The array, page size, address width and busy interval are all parameters. The array must be a power of two and larger than one page.

Top module: `spiee_target`

## Requirements
- R1: Bits are taken on rising `sck` and driven on falling `sck`, most significant bit first. `miso` is high-impedance whenever `cs_n` is high, and drives 0 during the instruction and address bytes.
- R2: Instruction 0x06 sets the write-enable latch and instruction 0x04 clears it. Either takes effect when `cs_n` rises on a byte boundary.
- R3: Instruction 0x05 returns the status byte, repeating it for as long as `cs_n` stays low. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the block-protect pair, bit 7 is the protect-enable flag, and bits 6:4 read 0.
- R4: Instruction 0x01, with the latch set, takes the next byte and keeps its bits 7, 3 and 2 when `cs_n` rises. It then starts a busy interval. With the latch clear the instruction is ignored.
- R5: Instruction 0x03 takes ADDR_BYTES address bytes, most significant first. It then returns consecutive array bytes for as long as `cs_n` stays low, and the address wraps from the last array byte to 0.
- R6: When ADDR9 is set, bit 3 of a read (0x03/0x0B) or write (0x02/0x0A) instruction is address bit 8, and the address byte supplies bits 7:0.
- R7: Instruction 0x02 is ignored while the write-enable latch is clear.
- R8: Write data fills a page in address order, starting at the addressed byte. The address wraps inside the page, and a later byte for the same slot replaces an earlier one.
- R9: Buffered write data reaches the array only when `cs_n` rises on a byte boundary after at least one data byte. A transfer cut off mid-byte, or one with no data byte, leaves the array, the busy flag and the latch unchanged.
- R10: Busy stays set for BUSY_CLKS system clocks after a committed write. While busy, only 0x05 is acted on: any other instruction changes nothing and returns 0 bytes.
- R11: The write-enable latch clears when the busy interval ends.
- R12: After reset the status byte reads 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out, high-impedance while deselected |

## Verification
The bench replays transaction patterns against a byte-level model of the array and the status byte:
- Plain sequential reads, and a read across the end of the array, separate address increment from array wrap.
- A write that starts two bytes before a page end, and a 17-byte write into a 16-byte page, separate page wrap from carrying into the next page.
- A write without the latch, one cut off mid-byte, and one with no data byte each show that nothing changed. This is observed through later reads and status polls.
- Instructions sent while busy, and the 9-bit address instructions checked against their aliases below 256, separate the busy gate from address decoding.

// File: rtl/spiee_pkg.sv
`timescale 1ns/1ps
// Shared opcode values, status bit positions and the command phase type.
package spiee_pkg;
    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_DATA = 8'h03;
    localparam logic [7:0] OP_WR_DATA = 8'h02;

    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;
    localparam int ST_BP0  = 2;
    localparam int ST_BP1  = 3;
    localparam int ST_WPEN = 7;

    typedef enum logic [2:0] {
        PH_OPCODE, PH_ADDR, PH_RDATA, PH_WDATA,
        PH_STAT_RD, PH_STAT_WR, PH_HOLD, PH_DROP
    } phase_e;
endpackage

// File: rtl/spiee_link.sv
`timescale 1ns/1ps
// Serial link: samples sck, cs_n and mosi into the system clock domain.
// It assembles received bytes and shifts a transmit byte out on falling sck.
// Assumes sck half periods of at least four system clocks.
module spiee_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       sel,
    output logic       sel_start,
    output logic       sel_end,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       on_boundary,
    output logic       tx_bit
);
    logic [2:0] sck_s, cs_s;
    logic [1:0] mosi_s;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise, fall;

    // Synchronise the bus pins and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= 3'b000;
            cs_s   <= 3'b111;
            mosi_s <= 2'b00;
        end else begin
            sck_s  <= {sck_s[1:0], sck};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign rise        = sck_s[1] & ~sck_s[2];
    assign fall        = ~sck_s[1] & sck_s[2];
    assign sel         = ~cs_s[1];
    assign sel_start   = ~cs_s[1] & cs_s[2];
    assign sel_end     = cs_s[1] & ~cs_s[2];
    assign on_boundary = (bit_cnt == 3'd0);

    // Receive: shift on rising sck and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= 3'd0;
            rx_sh    <= 7'd0;
            rx_valid <= 1'b0;
            rx_byte  <= 8'd0;
        end else begin
            rx_valid <= sel & rise & (bit_cnt == 3'd7);
            if (!sel) begin
                bit_cnt <= 3'd0;
            end else if (rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) rx_byte <= {rx_sh, mosi_s[1]};
            end
        end
    end

    // Transmit: on falling sck, load a fresh byte at a byte boundary, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= 8'd0;
            tx_bit <= 1'b0;
        end else if (!sel) begin
            tx_sh  <= 8'd0;
            tx_bit <= 1'b0;
        end else if (fall) begin
            if (bit_cnt == 3'd0) begin
                tx_bit <= tx_byte[7];
                tx_sh  <= {tx_byte[6:0], 1'b0};
            end else begin
                tx_bit <= tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |-> (bit_cnt == 3'd0)); // R1
endmodule

// File: rtl/spiee_pagebuf.sv
`timescale 1ns/1ps
// One-page write buffer: a data byte and a valid flag per slot.
// Cleared at the start of every transaction. Assumes PAGE_BYTES is a power of two.
module spiee_pagebuf #(
    parameter  int PAGE_BYTES = 16,
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [PW-1:0]           wr_slot,
    input  logic [7:0]              wr_data,
    output logic [PAGE_BYTES*8-1:0] slot_data,
    output logic [PAGE_BYTES-1:0]   slot_valid,
    output logic                    any_valid
);
    // Store a received byte in its slot, or forget all slots on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_data  <= '0;
            slot_valid <= '0;
        end else if (clear) begin
            slot_valid <= '0;
        end else if (wr_en) begin
            slot_data[{wr_slot, 3'b000} +: 8] <= wr_data;
            slot_valid[wr_slot]               <= 1'b1;
        end
    end

    assign any_valid = |slot_valid;
endmodule

// File: rtl/spiee_store.sv
`timescale 1ns/1ps
// Byte array with a combinational read port and a one-cycle page commit.
// Reset fills the array with the erased value 0xFF. MEM_BYTES must be a power of two.
module spiee_store #(
    parameter  int MEM_BYTES  = 512,
    parameter  int PAGE_BYTES = 16,
    localparam int AW         = $clog2(MEM_BYTES),
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           rd_addr,
    output logic [7:0]              rd_data,
    input  logic                    commit,
    input  logic [AW-PW-1:0]        commit_page,
    input  logic [PAGE_BYTES*8-1:0] slot_data,
    input  logic [PAGE_BYTES-1:0]   slot_valid
);
    logic [7:0] mem [MEM_BYTES];

    // Erase on reset; on commit, copy every valid slot into its page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int s = 0; s < PAGE_BYTES; s++)
                if (slot_valid[s]) mem[{commit_page, PW'(s)}] <= slot_data[s*8 +: 8];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spiee_target.sv
`timescale 1ns/1ps
// Serial EEPROM target: decodes instructions, captures the address and
// streams reads. It buffers page writes and commits them at deselect, and keeps
// the status byte with its busy interval.
// Assumes ADDR9 is used only with ADDR_BYTES == 1 and MEM_BYTES > PAGE_BYTES.
module spiee_target #(
    parameter int ADDR_BYTES = 1,
    parameter bit ADDR9      = 1'b1,
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    parameter int BUSY_CLKS  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    import spiee_pkg::*;

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int ACC_W = 8*ADDR_BYTES + (ADDR9 ? 1 : 0);
    localparam int BW    = $clog2(BUSY_CLKS + 1);
    localparam logic [1:0] ABYTES_LAST = 2'(ADDR_BYTES - 1);

    logic       sel, sel_start, sel_end, rx_valid, on_boundary, tx_bit;
    logic [7:0] rx_byte, tx_byte, mem_rd, status, stat_new, op_q;
    phase_e     phase;
    logic [1:0] abyte_left;
    logic [ACC_W-1:0] acc, acc_next;
    logic [AW-1:0]    cur_addr;
    logic [PAGE_BYTES*8-1:0] slot_data;
    logic [PAGE_BYTES-1:0]   slot_valid;
    logic       buf_any, buf_wr, end_ok, do_commit, do_stat;
    logic       wel, wpen, busy, is_rd, is_wr, op_q_rd;
    logic [1:0] bp;
    logic [BW-1:0] busy_cnt;

    spiee_link u_link (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(tx_byte), .sel(sel), .sel_start(sel_start), .sel_end(sel_end),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .on_boundary(on_boundary),
        .tx_bit(tx_bit)
    );

    spiee_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(sel_start), .wr_en(buf_wr),
        .wr_slot(cur_addr[PW-1:0]), .wr_data(rx_byte),
        .slot_data(slot_data), .slot_valid(slot_valid), .any_valid(buf_any)
    );

    spiee_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(cur_addr), .rd_data(mem_rd),
        .commit(do_commit), .commit_page(cur_addr[AW-1:PW]),
        .slot_data(slot_data), .slot_valid(slot_valid)
    );

    // Instruction decode; bit 3 of a data instruction is an address bit in 9-bit mode.
    always_comb begin
        is_rd   = ((ADDR9 ? (rx_byte & 8'hF7) : rx_byte) == OP_RD_DATA);
        is_wr   = ((ADDR9 ? (rx_byte & 8'hF7) : rx_byte) == OP_WR_DATA);
        op_q_rd = ((ADDR9 ? (op_q & 8'hF7) : op_q) == OP_RD_DATA);
        acc_next = ACC_W'({acc, rx_byte});
    end

    assign busy      = (busy_cnt != '0);
    assign buf_wr    = rx_valid && (phase == PH_WDATA);
    assign end_ok    = sel_end && on_boundary;
    assign do_commit = end_ok && (phase == PH_WDATA) && buf_any;
    assign do_stat   = end_ok && (phase == PH_HOLD) && (op_q == OP_WR_STAT);

    // Status byte assembly.
    always_comb begin
        status          = 8'h00;
        status[ST_BUSY] = busy;
        status[ST_WEL]  = wel;
        status[ST_BP0]  = bp[0];
        status[ST_BP1]  = bp[1];
        status[ST_WPEN] = wpen;
    end

    // Byte offered to the shifter at the next byte boundary.
    always_comb begin
        unique case (phase)
            PH_RDATA:   tx_byte = mem_rd;
            PH_STAT_RD: tx_byte = status;
            default:    tx_byte = 8'h00;
        endcase
    end

    assign miso = cs_n ? 1'bz : tx_bit;

    // Command phase sequencing per received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_OPCODE;
            op_q       <= 8'h00;
            abyte_left <= 2'd0;
            acc        <= '0;
            cur_addr   <= '0;
            stat_new   <= 8'h00;
        end else if (!sel) begin
            phase <= PH_OPCODE;
        end else if (rx_valid) begin
            unique case (phase)
                PH_OPCODE: begin
                    op_q       <= rx_byte;
                    abyte_left <= ABYTES_LAST;
                    acc        <= ACC_W'(ADDR9 ? rx_byte[3] : 1'b0);
                    if (rx_byte == OP_RD_STAT)      phase <= PH_STAT_RD;
                    else if (busy)                  phase <= PH_DROP;
                    else if (is_rd)                 phase <= PH_ADDR;
                    else if (is_wr)                 phase <= wel ? PH_ADDR : PH_DROP;
                    else if (rx_byte == OP_WR_STAT) phase <= wel ? PH_STAT_WR : PH_DROP;
                    else if (rx_byte == OP_SET_WEL || rx_byte == OP_CLR_WEL) phase <= PH_HOLD;
                    else                            phase <= PH_DROP;
                end
                PH_ADDR: begin
                    acc        <= acc_next;
                    abyte_left <= abyte_left - 2'd1;
                    if (abyte_left == 2'd0) begin
                        cur_addr <= AW'(acc_next);
                        phase    <= op_q_rd ? PH_RDATA : PH_WDATA;
                    end
                end
                PH_RDATA: cur_addr <= cur_addr + AW'(1);
                PH_WDATA: cur_addr <= {cur_addr[AW-1:PW], cur_addr[PW-1:0] + PW'(1)};
                PH_STAT_WR: begin
                    stat_new <= rx_byte;
                    phase    <= PH_HOLD;
                end
                default: ;
            endcase
        end
    end

    // Busy interval, write-enable latch and protection bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel      <= 1'b0;
            bp       <= 2'b00;
            wpen     <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - BW'(1);
            if (do_commit || do_stat) busy_cnt <= BW'(BUSY_CLKS);
            if (do_stat) begin
                bp   <= stat_new[3:2];
                wpen <= stat_new[7];
            end
            if (busy_cnt == BW'(1))
                wel <= 1'b0;
            else if (end_ok && phase == PH_HOLD && op_q == OP_SET_WEL)
                wel <= 1'b1;
            else if (end_ok && phase == PH_HOLD && op_q == OP_CLR_WEL)
                wel <= 1'b0;
        end
    end

    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        do_commit |-> wel); // R7
    AST_BUSY_GATES_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPCODE && rx_valid && sel && busy)
        |=> (!sel || phase == PH_STAT_RD || phase == PH_DROP)); // R10
    AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy_cnt == $past(busy_cnt) - BW'(1))); // R10
    AST_WEL_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt == BW'(1)) |=> !wel); // R11
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WDATA && rx_valid && sel)
        |=> (cur_addr[AW-1:PW] == $past(cur_addr[AW-1:PW]))); // R8
endmodule

// File: tb/spiee_target_tb_top.sv
`timescale 1ns/1ps
module spiee_target_tb_top;
    localparam int BUSY = 2000;
    localparam int MEMN = 512;
    localparam int PG   = 16;
    localparam int HP   = 8;

    typedef logic [7:0] bq_t [$];

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    wire  miso;
    int   total = 0, bad = 0;
    bit   done = 1'b0;

    logic [7:0] mem_m [MEMN];
    logic wel_m = 1'b0, busy_m = 1'b0, wpen_m = 1'b0;
    logic [1:0] bp_m = 2'b00;
    logic [7:0] rxq [$];

    always #4 clk = ~clk;

    spiee_target #(.ADDR_BYTES(1), .ADDR9(1'b1), .MEM_BYTES(MEMN),
                   .PAGE_BYTES(PG), .BUSY_CLKS(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // R1: compared on every clock while deselected
    always @(posedge clk) begin
        if (rst_n && cs_n && !done) begin
            total++;
            if (miso !== 1'bz) begin
                bad++;
                $display("FAIL R1 actual=%b expected=z", miso);
            end
        end
    end

    function automatic logic [7:0] stat_exp();
        return {wpen_m, 3'b000, bp_m, wel_m, busy_m};
    endfunction

    task automatic clkn(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk); mosi = tx[7-i];
            clkn(HP);
            @(negedge clk); rx = {rx[6:0], miso}; sck = 1'b1;
            clkn(HP);
            @(negedge clk); sck = 1'b0;
        end
    endtask

    task automatic txn(input bq_t b, input int tail);
        logic [7:0] r;
        rxq.delete();
        @(negedge clk); cs_n = 1'b0;
        clkn(HP);
        foreach (b[i]) begin
            xfer_bits(b[i], 8, r);
            rxq.push_back(r);
        end
        if (tail > 0) xfer_bits(8'hA5, tail, r);
        clkn(HP);
        @(negedge clk); cs_n = 1'b1;
        clkn(2*HP);
    endtask

    task automatic op_wren();
        txn('{8'h06}, 0);
        if (!busy_m) wel_m = 1'b1;
    endtask

    task automatic op_wrdi();
        txn('{8'h04}, 0);
        if (!busy_m) wel_m = 1'b0;
    endtask

    task automatic op_rdsr(input string req, input int n);
        bq_t b;
        b.push_back(8'h05);
        for (int i = 0; i < n; i++) b.push_back(8'h00);
        txn(b, 0);
        chk("R1 opcode byte", rxq[0], 8'h00);
        for (int i = 0; i < n; i++) chk(req, rxq[1+i], stat_exp());
    endtask

    task automatic op_wrsr(input logic [7:0] v);
        txn('{8'h01, v}, 0);
        if (wel_m && !busy_m) begin
            wpen_m = v[7]; bp_m = v[3:2]; busy_m = 1'b1;
        end
    endtask

    task automatic op_write(input logic [8:0] addr, input bq_t data, input int tail);
        bq_t b;
        int a, base, off;
        b.push_back(8'h02 | {4'b0000, addr[8], 3'b000});
        b.push_back(addr[7:0]);
        foreach (data[i]) b.push_back(data[i]);
        txn(b, tail);
        if (wel_m && !busy_m && tail == 0 && data.size() > 0) begin
            a = int'(addr); base = a - (a % PG); off = a % PG;
            foreach (data[i]) begin
                mem_m[base+off] = data[i];
                off = (off + 1) % PG;
            end
            busy_m = 1'b1;
        end
    endtask

    task automatic op_read(input string req, input logic [8:0] addr, input int n);
        bq_t b;
        logic [7:0] e;
        b.push_back(8'h03 | {4'b0000, addr[8], 3'b000});
        b.push_back(addr[7:0]);
        for (int i = 0; i < n; i++) b.push_back(8'h00);
        txn(b, 0);
        chk("R1 address byte", rxq[1], 8'h00);
        for (int i = 0; i < n; i++) begin
            e = busy_m ? 8'h00 : mem_m[(int'(addr) + i) % MEMN];
            chk(req, rxq[2+i], e);
        end
    endtask

    task automatic wait_ready();
        clkn(BUSY + 200);
        if (busy_m) begin busy_m = 1'b0; wel_m = 1'b0; end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        bq_t d;
        for (int i = 0; i < MEMN; i++) mem_m[i] = 8'hFF;
        clkn(5);
        @(negedge clk); rst_n = 1'b1;
        clkn(5);

        op_rdsr("R12 status after reset", 1);
        op_read("R12 erased array", 9'h000, 2);

        op_write(9'h010, '{8'h11, 8'h22}, 0);
        op_read("R7 write without latch", 9'h010, 2);
        op_rdsr("R7 no busy after ignored write", 1);

        op_wren();
        op_rdsr("R2 latch set", 1);

        op_write(9'h010, '{8'hA1, 8'hB2, 8'hC3}, 0);
        op_rdsr("R3 R10 busy status repeated", 2);
        op_read("R10 read while busy returns 0", 9'h010, 2);
        op_wren();
        wait_ready();
        op_rdsr("R11 latch cleared after busy", 1);
        op_read("R5 sequential read", 9'h010, 4);

        op_wren();
        op_write(9'h01E, '{8'h5A, 8'h6B, 8'h7C, 8'h8D}, 0);
        wait_ready();
        op_read("R8 page wrap", 9'h01C, 8);

        op_wren();
        op_write(9'h105, '{8'hE1, 8'hE2}, 0);
        wait_ready();
        op_read("R6 nine-bit address", 9'h105, 2);
        op_read("R6 low alias untouched", 9'h005, 1);

        op_wren();
        op_write(9'h1FF, '{8'h99}, 0);
        wait_ready();
        op_wren();
        op_write(9'h000, '{8'h77}, 0);
        wait_ready();
        op_read("R5 read wraps at array end", 9'h1FE, 3);

        op_wren();
        op_write(9'h040, '{8'h12, 8'h34}, 3);
        op_rdsr("R9 aborted write keeps latch no busy", 1);
        op_read("R9 aborted write leaves array", 9'h040, 2);
        d.delete();
        op_write(9'h041, d, 0);
        op_rdsr("R9 empty write starts nothing", 1);

        op_wrdi();
        op_rdsr("R2 latch cleared by 0x04", 1);

        op_wrsr(8'h8F);
        op_rdsr("R4 status write without latch", 1);
        op_wren();
        op_wrsr(8'h8F);
        op_rdsr("R4 status write busy", 1);
        wait_ready();
        op_rdsr("R4 protect bits stored", 1);

        op_wren();
        d.delete();
        for (int i = 1; i <= 17; i++) d.push_back(8'(i));
        op_write(9'h030, d, 0);
        wait_ready();
        op_read("R8 overfull page replaces first slot", 9'h030, 17);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule